// File: doc/BRIEF.md
# Asynchronous Reformatter with Stop Shortening

This block sits at the far end of a synchronous-to-asynchronous path. It takes recovered words from the head of a receive FIFO and rebuilds start/stop serial characters on a single output line. Each character has a low start bit, then 8 or 9 data bits with the least significant bit first, then one or two high stop bits. All bit timing comes from a single-cycle enable that pulses at OVS times the bit rate. The transmit side of the link uses the same rate.

The far-end sender's clock may run slightly fast. To absorb that slip, the block trims the final stop bit whenever another word is already waiting at the FIFO head as that stop bit begins. Successive trimmed stop bits alternate between full length and one tick short, so on average each one loses half a tick, which is 1/32 of a bit at OVS = 16. A break indication drives the line low without a break while the block sits between characters. While the receiver is in its hold state, the line stays at mark and no words are taken.

Top module: `rf_async_reformat`

## Requirements
- R1: A character is a low start bit, then the data bits least significant first, then stop bits. Every bit lasts OVS ticks of tick_i unless R7 trims it. word_long_i high selects WORD_MAX data bits (9) and low selects WORD_MIN (8). The length and stop settings are taken when the word is popped. The line only falls in the cycle after a tick.
- R2: stop_two_i high gives two high stop bits and low gives one. Only the last stop bit can be trimmed.
- R3: With no word waiting, no break and no hold, the line stays high and fifo_pop_o stays low.
- R4: When brk_i is high and the block is between characters, the line goes low at the next tick and stays low, and no word is taken. After brk_i falls, the line returns high at the next tick.
- R5: While hold_i is high, no word is popped. From the cycle after hold_i is seen the line is high, and any character in progress is abandoned. Words are taken again once hold_i falls.
- R6: fifo_pop_o is a one-cycle strobe. It is only asserted together with tick_i and fifo_valid_i, and the start bit appears in the next cycle.
- R7: When a word is waiting (valid, no break, no hold) as the last stop bit begins, that stop bit is trimmed and the next start bit follows it at once. Counting trimmed stop bits from reset, the odd-numbered ones keep full length and the even-numbered ones are one tick shorter.
- R8: When no word is waiting as the last stop bit begins, that stop bit keeps its full OVS ticks.
- R9: During reset the line is high and fifo_pop_o is low. Reset abandons a character in progress and restarts the R7 trim numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at OVS times the bit rate |
| word_long_i | input | 1 | High: WORD_MAX data bits; low: WORD_MIN |
| stop_two_i | input | 1 | High: two stop bits; low: one |
| hold_i | input | 1 | Receiver hold: line at mark, no words taken |
| brk_i | input | 1 | Break indication from the receiver |
| fifo_valid_i | input | 1 | A word is present at the FIFO head |
| fifo_word_i | input | WORD_MAX | Word at the FIFO head |
| fifo_pop_o | output | 1 | Takes the head word (one cycle) |
| line_o | output | 1 | Regenerated asynchronous serial line |

## Verification
The bench builds the block with OVS = 4, 9- and 8-bit word lengths, trimming enabled, and a tick every third clock. With these values a bit lasts 12 clocks and a trimmed stop bit is exactly 3 clocks short, so the alternation between full and short stop bits can be measured to the cycle. All four combinations of word length and stop count are run with three-word bursts, each only a few hundred cycles long. The same small bit time keeps the break, hold-abort and mid-character reset cases short enough to observe, including the restart of the trim numbering after reset.

// File: rtl/rf_pkg.sv
package rf_pkg;

   typedef enum logic [2:0] {
      RF_IDLE,
      RF_START,
      RF_DATA,
      RF_STOP,
      RF_BREAK
   } rf_state_e;

   // counter width able to hold 0 .. n-1
   function automatic int unsigned rf_cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rf_bit_timer.sv
// Counts ticks inside one bit; a trimmed bit ends one tick early.
module rf_bit_timer #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clr_i,
   input  logic trim_i,
   output logic bit_end_o
);
   localparam int CW = rf_pkg::rf_cnt_w(OVS);
   localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
   localparam logic [CW-1:0] TRIM_LAST = CW'(OVS - 2);

   if (OVS < 2) begin : g_bad_ovs
      $error("rf_bit_timer: OVS must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign bit_end_o = tick_i && !clr_i &&
                      (cnt_q == (trim_i ? TRIM_LAST : FULL_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= bit_end_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rf_stop_trim.sv
// Half-tick accumulator: trimmed stop bits alternate full / one tick short.
module rf_stop_trim #(
   parameter bit TRIM_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic waiting_i,
   output logic short_o
);
   if (TRIM_EN) begin : g_trim
      logic acc_q;
      logic short_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q   <= 1'b0;
            short_q <= 1'b0;
         end else if (enter_i) begin
            short_q <= waiting_i & acc_q;
            if (waiting_i) begin
               acc_q <= ~acc_q;
            end
         end
      end

      assign short_o = short_q;
   end else begin : g_flat
      logic unused_trim;
      assign unused_trim = ^{clk, rst_n, enter_i, waiting_i};
      assign short_o     = 1'b0;
   end
endmodule

// File: rtl/rf_shift.sv
// Data shift register, least significant bit out first.
module rf_shift #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         shift_i,
   output logic         bit_o
);
   if (W < 2) begin : g_bad_w
      $error("rf_shift: W must be at least 2");
   end

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '1;
      end else if (load_i) begin
         sr_q <= data_i;
      end else if (shift_i) begin
         sr_q <= {1'b1, sr_q[W-1:1]};
      end
   end

   assign bit_o = sr_q[0];
endmodule

// File: rtl/rf_async_reformat.sv
module rf_async_reformat #(
   parameter int OVS      = 16,
   parameter int WORD_MAX = 9,
   parameter int WORD_MIN = 8,
   parameter bit TRIM_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                word_long_i,
   input  logic                stop_two_i,
   input  logic                hold_i,
   input  logic                brk_i,
   input  logic                fifo_valid_i,
   input  logic [WORD_MAX-1:0] fifo_word_i,
   output logic                fifo_pop_o,
   output logic                line_o
);
   import rf_pkg::*;

   localparam int IW = rf_cnt_w(WORD_MAX);
   localparam logic [IW-1:0] LAST_LONG  = IW'(WORD_MAX - 1);
   localparam logic [IW-1:0] LAST_SHORT = IW'(WORD_MIN - 1);

   if (WORD_MIN < 1 || WORD_MAX < WORD_MIN) begin : g_bad_len
      $error("rf_async_reformat: need 1 <= WORD_MIN <= WORD_MAX");
   end

   rf_state_e     state_q;
   logic [IW-1:0] bit_idx_q;
   logic          stop_idx_q;
   logic          cfg_long_q;
   logic          cfg_two_q;

   logic bit_end;
   logic last_data;
   logic in_final_stop;
   logic word_ready;
   logic enter_final;
   logic launch;
   logic stop_short;
   logic data_bit;
   logic timer_clr;

   assign last_data     = (bit_idx_q == (cfg_long_q ? LAST_LONG : LAST_SHORT));
   assign in_final_stop = (state_q == RF_STOP) && (stop_idx_q == cfg_two_q);
   assign word_ready    = fifo_valid_i && !hold_i && !brk_i;
   assign enter_final   = bit_end &&
                          (((state_q == RF_DATA) && last_data && !cfg_two_q) ||
                           ((state_q == RF_STOP) && !stop_idx_q && cfg_two_q));
   assign launch        = tick_i && word_ready &&
                          ((state_q == RF_IDLE) || (in_final_stop && bit_end));
   assign timer_clr     = hold_i || (state_q == RF_IDLE) || (state_q == RF_BREAK);
   assign fifo_pop_o    = launch;

   rf_bit_timer #(.OVS(OVS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .clr_i     (timer_clr),
      .trim_i    (stop_short && in_final_stop),
      .bit_end_o (bit_end)
   );

   rf_stop_trim #(.TRIM_EN(TRIM_EN)) u_trim (
      .clk       (clk),
      .rst_n     (rst_n),
      .enter_i   (enter_final),
      .waiting_i (word_ready),
      .short_o   (stop_short)
   );

   rf_shift #(.W(WORD_MAX)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (launch),
      .data_i  (fifo_word_i),
      .shift_i ((state_q == RF_DATA) && bit_end),
      .bit_o   (data_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RF_IDLE;
         bit_idx_q  <= '0;
         stop_idx_q <= 1'b0;
         cfg_long_q <= 1'b0;
         cfg_two_q  <= 1'b0;
      end else if (hold_i) begin
         state_q    <= RF_IDLE;
         bit_idx_q  <= '0;
         stop_idx_q <= 1'b0;
      end else begin
         case (state_q)
            RF_IDLE: begin
               if (tick_i && brk_i) begin
                  state_q <= RF_BREAK;
               end else if (launch) begin
                  state_q    <= RF_START;
                  cfg_long_q <= word_long_i;
                  cfg_two_q  <= stop_two_i;
               end
            end
            RF_START: begin
               if (bit_end) begin
                  state_q   <= RF_DATA;
                  bit_idx_q <= '0;
               end
            end
            RF_DATA: begin
               if (bit_end) begin
                  if (last_data) begin
                     state_q    <= RF_STOP;
                     stop_idx_q <= 1'b0;
                  end else begin
                     bit_idx_q <= bit_idx_q + 1'b1;
                  end
               end
            end
            RF_STOP: begin
               if (bit_end) begin
                  if (!in_final_stop) begin
                     stop_idx_q <= 1'b1;
                  end else if (launch) begin
                     state_q    <= RF_START;
                     stop_idx_q <= 1'b0;
                     cfg_long_q <= word_long_i;
                     cfg_two_q  <= stop_two_i;
                  end else if (brk_i) begin
                     state_q    <= RF_BREAK;
                     stop_idx_q <= 1'b0;
                  end else begin
                     state_q    <= RF_IDLE;
                     stop_idx_q <= 1'b0;
                  end
               end
            end
            RF_BREAK: begin
               if (tick_i && !brk_i) begin
                  state_q <= RF_IDLE;
               end
            end
            default: state_q <= RF_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state_q)
         RF_START: line_o = 1'b0;
         RF_BREAK: line_o = 1'b0;
         RF_DATA:  line_o = data_bit;
         default:  line_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/rf_async_reformat_chk.sv
module rf_async_reformat_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_i,
   input logic hold_i,
   input logic brk_i,
   input logic fifo_valid_i,
   input logic fifo_pop_o,
   input logic line_o
);
   // R1
   fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_o) |-> $past(tick_i));

   // R3
   empty_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_valid_i |-> !fifo_pop_o);

   // R4
   brk_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_i |-> !fifo_pop_o);

   // R5
   hold_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |-> !fifo_pop_o);

   // R5
   hold_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> line_o);

   // R6
   pop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop_o |-> tick_i);

   // R6
   pop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop_o |=> !line_o);
endmodule

bind rf_async_reformat rf_async_reformat_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_i       (tick_i),
   .hold_i       (hold_i),
   .brk_i        (brk_i),
   .fifo_valid_i (fifo_valid_i),
   .fifo_pop_o   (fifo_pop_o),
   .line_o       (line_o)
);

// File: tb/sim_rf_async_reformat.sv
module sim_rf_async_reformat;
   localparam int OVS  = 4;
   localparam int TP   = 3;
   localparam int BITC = OVS * TP;
   localparam int WMAX = 9;
   localparam int WMIN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic word_long = 1'b0;
   logic stop_two = 1'b0;
   logic hold = 1'b0;
   logic brk = 1'b0;
   logic fifo_valid = 1'b0;
   logic [WMAX-1:0] fifo_word = '0;
   logic pop;
   logic line;

   logic [WMAX-1:0] q[$];
   int checks = 0;
   int fails = 0;
   int trims = 0;
   int tcnt = 0;
   logic pop_seen = 1'b0;
   logic pop_prev = 1'b0;
   int pop_bad = 0;
   bit finished = 1'b0;

   rf_async_reformat #(.OVS(OVS), .WORD_MAX(WMAX), .WORD_MIN(WMIN), .TRIM_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .word_long_i(word_long),
      .stop_two_i(stop_two), .hold_i(hold), .brk_i(brk),
      .fifo_valid_i(fifo_valid), .fifo_word_i(fifo_word),
      .fifo_pop_o(pop), .line_o(line)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (tcnt == TP - 1) begin
         tcnt <= 0;
         tick <= 1'b1;
      end else begin
         tcnt <= tcnt + 1;
         tick <= 1'b0;
      end
   end

   always @(posedge clk) begin
      pop_seen <= rst_n && pop;
      pop_prev <= rst_n && pop;
      if (rst_n && pop && (!tick || pop_prev || !fifo_valid)) pop_bad <= pop_bad + 1;
   end

   task automatic refresh();
      fifo_valid = (q.size() != 0);
      fifo_word  = (q.size() != 0) ? q[0] : '0;
   endtask

   task automatic push(input logic [WMAX-1:0] w);
      q.push_back(w);
      refresh();
   endtask

   always @(negedge clk) begin
      if (pop_seen && q.size() > 0) begin
         void'(q.pop_front());
         refresh();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // receive one character; exp_stop is the expected stop length in clocks
   task automatic rx_char(input int n, input int s, input logic [WMAX-1:0] w,
                          input int exp_stop, input bit last);
      int wt;
      int off;
      int hi;
      int cap;
      logic [WMAX-1:0] got;
      logic [WMAX-1:0] expw;
      wt = 0;
      while (line !== 1'b0 && wt < 3000) begin
         @(negedge clk);
         wt++;
      end
      chk(wt < 3000, "R1 start bit appears", wt, 0);
      repeat (BITC / 2) @(negedge clk);
      off = BITC / 2;
      chk(line === 1'b0, "R1 start bit low", int'(line), 0);
      got = '0;
      for (int k = 0; k < n; k++) begin
         repeat ((1 + k) * BITC + BITC / 2 - off) @(negedge clk);
         off = (1 + k) * BITC + BITC / 2;
         got[k] = line;
      end
      expw = (n == WMAX) ? w : (w & WMAX'((1 << n) - 1));
      chk(got === expw, "R1 data bits lsb first", int'(got), int'(expw));
      repeat ((1 + n) * BITC - off) @(negedge clk);
      cap = last ? s * BITC : s * BITC + BITC;
      hi = 0;
      while (line === 1'b1 && hi < cap) begin
         hi++;
         @(negedge clk);
      end
      if (last) chk(hi == s * BITC, "R2 R8 untrimmed stop length", hi, s * BITC);
      else      chk(hi == exp_stop, "R2 R7 trimmed stop length", hi, exp_stop);
   endtask

   task automatic burst(input bit lng, input bit two, input logic [WMAX-1:0] a,
                        input logic [WMAX-1:0] b, input logic [WMAX-1:0] c);
      int n;
      int s;
      int e;
      @(negedge clk);
      word_long = lng;
      stop_two  = two;
      n = lng ? WMAX : WMIN;
      s = two ? 2 : 1;
      push(a);
      push(b);
      push(c);
      trims++;
      e = s * BITC - ((trims % 2 == 0) ? TP : 0);
      rx_char(n, s, a, e, 1'b0);
      trims++;
      e = s * BITC - ((trims % 2 == 0) ? TP : 0);
      rx_char(n, s, b, e, 1'b0);
      rx_char(n, s, c, 0, 1'b1);
      chk(q.size() == 0, "R6 every burst word taken", q.size(), 0);
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int cnt;
      // R9 reset state
      repeat (5) @(negedge clk);
      chk(line === 1'b1, "R9 line high in reset", int'(line), 1);
      chk(pop === 1'b0, "R9 no pop in reset", int'(pop), 0);
      rst_n = 1'b1;

      // R3 idle with empty FIFO
      cnt = 0;
      repeat (50) begin
         @(negedge clk);
         if (line === 1'b1 && pop === 1'b0) cnt++;
      end
      chk(cnt == 50, "R3 idle at mark without pops", cnt, 50);

      // R1 R2 R7 R8 sweep of formats
      burst(1'b0, 1'b0, 9'h0A5, 9'h05A, 9'h0FF);
      burst(1'b1, 1'b0, 9'h1A5, 9'h001, 9'h100);
      burst(1'b0, 1'b1, 9'h0C3, 9'h03C, 9'h080);
      burst(1'b1, 1'b1, 9'h155, 9'h0AA, 9'h1FF);

      // R8 isolated word
      @(negedge clk);
      word_long = 1'b0;
      stop_two  = 1'b0;
      push(9'h036);
      rx_char(WMIN, 1, 9'h036, 0, 1'b1);

      // R4 break
      @(negedge clk);
      brk = 1'b1;
      repeat (2 * TP + 2) @(negedge clk);
      chk(line === 1'b0, "R4 break drives low", int'(line), 0);
      push(9'h011);
      cnt = 0;
      repeat (40) begin
         @(negedge clk);
         if (line === 1'b0) cnt++;
      end
      chk(cnt == 40, "R4 break low continuously", cnt, 40);
      chk(q.size() == 1, "R4 no word taken in break", q.size(), 1);
      brk = 1'b0;
      repeat (TP + 1) @(negedge clk);
      chk(line === 1'b1 || q.size() == 0, "R4 line released after break", int'(line), 1);
      rx_char(WMIN, 1, 9'h011, 0, 1'b1);

      // R5 hold with a waiting word
      @(negedge clk);
      hold = 1'b1;
      push(9'h0E7);
      cnt = 0;
      repeat (60) begin
         @(negedge clk);
         if (line === 1'b1) cnt++;
      end
      chk(cnt == 60, "R5 mark during hold", cnt, 60);
      chk(q.size() == 1, "R5 no word taken in hold", q.size(), 1);
      hold = 1'b0;
      rx_char(WMIN, 1, 9'h0E7, 0, 1'b1);

      // R5 hold abandons a character in progress
      @(negedge clk);
      push(9'h000);
      while (line !== 1'b0) @(negedge clk);
      repeat (3 * BITC) @(negedge clk);
      hold = 1'b1;
      @(negedge clk);
      chk(line === 1'b1, "R5 hold aborts character", int'(line), 1);
      cnt = 0;
      repeat (30) begin
         @(negedge clk);
         if (line === 1'b1) cnt++;
      end
      chk(cnt == 30, "R5 stays at mark after abort", cnt, 30);
      chk(q.size() == 0, "R5 aborted word was taken", q.size(), 0);
      hold = 1'b0;

      // R9 reset mid-character restarts trim numbering
      @(negedge clk);
      push(9'h000);
      push(9'h0F0);
      while (line !== 1'b0) @(negedge clk);
      repeat (2 * BITC) @(negedge clk);
      rst_n = 1'b0;
      q.delete();
      refresh();
      @(negedge clk);
      chk(line === 1'b1, "R9 reset abandons character", int'(line), 1);
      rst_n = 1'b1;
      trims = 0;
      burst(1'b0, 1'b0, 9'h0F1, 9'h00E, 9'h077);
      burst(1'b1, 1'b0, 9'h18C, 9'h073, 9'h101);

      chk(pop_bad == 0, "R6 pop one cycle with tick and valid", pop_bad, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule